// File: doc/BRIEF.md
# I2C Slave Address-Phase Front End

This block is the bus-facing front end of an I2C target device. It samples SCL and SDA with the system clock, which must run at eight or more times the bit rate. It finds START and STOP conditions and shifts in the seven address bits and the direction bit. It then decides whether to acknowledge the ninth clock by pulling SDA low through an open-drain output. Control inputs supply a block enable, an acknowledge mode, an asynchronous-detect mode and the device's own address.

After an acknowledged address, the data phase is only a placeholder. It counts complete nine-clock bytes until the next STOP or START. It does not drive SDA during that phase. Status outputs report the following:
- bus occupancy;
- selection;
- the captured direction;
- a sticky asynchronous-match flag, which comes with a one-cycle interrupt pulse.

Top module: `i2cs_addr_phase`

## Requirements
- R1: While `en` is 0 the block ignores the bus: `busy`, `selected` and `sda_pull` stay 0 whatever SCL and SDA do.
- R2: A START (SDA falling while SCL is high) sets `busy`. A STOP (SDA rising while SCL is high) clears both `busy` and `selected`.
- R3: When the seven address bits (most significant first) equal `own_addr`, `ack_mode` is 1 and `async_en` is 0, `sda_pull` is 1 during the ninth SCL high phase and `selected` becomes 1.
- R4: A non-matching address gets no acknowledge. `selected` stays 0, and `busy` stays 1 until STOP.
- R5: A matching address with `ack_mode` at 0 gets no acknowledge, and `selected` stays 0.
- R6: On an acknowledged address, `rw` takes the eighth received bit. 0 means the master writes to the device, and 1 means the device sends to the master.
- R7: A matching address with `async_en` at 1 sets `async_hit`, raises `irq` for exactly one clock, gets no acknowledge and leaves `selected` at 0.
- R8: `async_hit` stays set until `async_clr` is 1 for a clock. Without that pulse, neither further bus traffic nor time clears it.
- R9: `sda_pull` is released on the SCL falling edge that ends the ninth clock, and it is 0 before the master's next bit.
- R10: A START that arrives before any STOP restarts the address phase and keeps `busy` at 1. A matching address that follows it is acknowledged.
- R11: After an acknowledge, `xfer_bytes` counts each complete group of nine SCL clocks modulo 2^CNT_W. A START resets it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable |
| ack_mode | input | 1 | 1: acknowledge own address |
| async_en | input | 1 | Asynchronous-detect mode |
| own_addr | input | 7 | Device address |
| async_clr | input | 1 | Write-one-to-clear for `async_hit` |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull | output | 1 | 1: pull SDA low |
| busy | output | 1 | Bus busy between START and STOP |
| selected | output | 1 | Device addressed and acknowledged |
| rw | output | 1 | Captured direction bit |
| async_hit | output | 1 | Sticky asynchronous match flag |
| irq | output | 1 | One-cycle status interrupt pulse |
| xfer_bytes | output | CNT_W | Bytes counted in the data phase |

## Verification
The bench builds the block with CNT_W at 3, so the byte counter wraps after eight bytes. A short data phase can therefore reach the wrap. SCL quarter-periods of five clocks keep the sampling clock at twenty times the bit rate. The bench sweeps all 128 addresses against a fixed own address, with the direction bit alternating. This covers every mismatch pattern, including addresses one bit away from the own address.

// File: rtl/i2cs_addr_phase.sv
module i2cs_addr_phase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ack_mode,
  input  logic             async_en,
  input  logic [6:0]       own_addr,
  input  logic             async_clr,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull,
  output logic             busy,
  output logic             selected,
  output logic             rw,
  output logic             async_hit,
  output logic             irq,
  output logic [CNT_W-1:0] xfer_bytes
);
  localparam int LAST_BIT = 8;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_DATA, S_SKIP} st_t;

  logic [1:0] scl_m, sda_m;
  logic       scl_q, sda_q;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  st_t        st;

  wire scl_s    = scl_m[1];
  wire sda_s    = sda_m[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire hit      = (shreg[7:1] == own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      sda_pull   <= 1'b0;
      busy       <= 1'b0;
      selected   <= 1'b0;
      rw         <= 1'b0;
      async_hit  <= 1'b0;
      irq        <= 1'b0;
      xfer_bytes <= '0;
    end else begin
      irq <= 1'b0;
      if (async_clr) async_hit <= 1'b0;
      if (!en) begin
        st       <= S_IDLE;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
        busy     <= 1'b0;
        selected <= 1'b0;
      end else if (stop_c) begin
        st       <= S_IDLE;
        sda_pull <= 1'b0;
        busy     <= 1'b0;
        selected <= 1'b0;
      end else if (start_c) begin
        st         <= S_ADDR;
        bit_cnt    <= '0;
        sda_pull   <= 1'b0;
        busy       <= 1'b1;
        xfer_bytes <= '0;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'(LAST_BIT)) begin
              bit_cnt <= '0;
              if (hit && async_en) begin
                async_hit <= 1'b1;
                irq       <= 1'b1;
                st        <= S_SKIP;
              end else if (hit && ack_mode) begin
                sda_pull <= 1'b1;
                selected <= 1'b1;
                rw       <= shreg[0];
                st       <= S_ACK;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              st       <= S_DATA;
            end
          end
          S_DATA: begin
            if (scl_rise) begin
              if (bit_cnt == 4'(LAST_BIT)) begin
                bit_cnt    <= '0;
                xfer_bytes <= xfer_bytes + 1'b1;
              end else begin
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_addr_phase_chk.sv
module i2cs_addr_phase_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic async_clr,
  input logic sda_pull,
  input logic busy,
  input logic selected,
  input logic async_hit,
  input logic irq
);
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !selected && !sda_pull));

  p_sel_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    selected |-> busy);

  p_pull_when_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> selected);

  p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> async_hit);

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (async_hit && !async_clr) |=> async_hit);
endmodule

bind i2cs_addr_phase i2cs_addr_phase_chk chk_i (.*);

// File: tb/i2cs_addr_phase_tb_top.sv
module i2cs_addr_phase_tb_top;
  localparam int CW = 3;
  localparam int Q = 5;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 0, rst_n = 0;
  logic en = 0, ack_mode = 0, async_en = 0, async_clr = 0;
  logic m_scl = 1, m_sda = 1;
  logic sda_pull, busy, selected, rw, async_hit, irq;
  logic [CW-1:0] xfer_bytes;
  wire sda_line = m_sda & ~sda_pull;

  int total = 0, bad = 0, irq_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2cs_addr_phase #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .ack_mode(ack_mode), .async_en(async_en),
    .own_addr(OWN), .async_clr(async_clr), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull(sda_pull), .busy(busy), .selected(selected), .rw(rw),
    .async_hit(async_hit), .irq(irq), .xfer_bytes(xfer_bytes));

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wq(int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1; wq(); m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq();
  endtask

  task automatic bstop();
    m_scl = 0; m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq(2);
  endtask

  task automatic bbit(input logic b);
    m_scl = 0; wq(); m_sda = b; wq(); m_scl = 1; wq(2); m_scl = 0;
  endtask

  task automatic addr_frame(input logic [6:0] a, input logic d, output logic ack,
                            output logic sel_mid);
    for (int i = 6; i >= 0; i--) bbit(a[i]);
    bbit(d);
    m_scl = 0; wq(); m_sda = 1; wq(); m_scl = 1; wq();
    ack = ~sda_line;
    sel_mid = selected;
    wq(); m_scl = 0; wq();
    check("R9 released after ninth clock", sda_pull, 0);
  endtask

  task automatic data_bytes(int n);
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 9; i++) bbit(1'b1);
  endtask

  initial begin
    logic ack, sm;
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset selected", selected, 0);
    check("R8 reset async_hit", async_hit, 0);
    rst_n = 1; wq();

    bstart();
    check("R1 busy while disabled", busy, 0);
    addr_frame(OWN, 0, ack, sm);
    check("R1 no ack while disabled", ack, 0);
    check("R1 not selected while disabled", selected, 0);
    bstop();

    en = 1; ack_mode = 1; wq();
    for (int a = 0; a < 128; a++) begin
      logic d;
      d = a[0];
      bstart();
      check("R2 busy after start", busy, 1);
      addr_frame(7'(a), d, ack, sm);
      check(a == OWN ? "R3 ack own address" : "R4 no ack foreign address",
            ack, a == OWN);
      check("R3 R4 selected", selected, a == OWN);
      if (a == OWN) check("R6 direction captured", rw, d);
      else check("R4 busy held", busy, 1);
      bstop();
      check("R2 busy cleared by stop", busy, 0);
      check("R2 selected cleared by stop", selected, 0);
    end

    bstart(); addr_frame(OWN, 1, ack, sm);
    check("R6 transmit direction", rw, 1);
    bstop();

    ack_mode = 0;
    bstart(); addr_frame(OWN, 0, ack, sm);
    check("R5 nak with ack_mode 0", ack, 0);
    check("R5 not selected", selected, 0);
    bstop();
    ack_mode = 1;

    bstart(); addr_frame(OWN ^ 7'h01, 0, ack, sm);
    check("R4 mismatch nak", ack, 0);
    bstart();
    check("R10 busy held across repeated start", busy, 1);
    addr_frame(OWN, 0, ack, sm);
    check("R10 ack after repeated start", ack, 1);
    check("R10 selected", selected, 1);
    data_bytes(10);
    check("R11 byte count wraps", xfer_bytes, 10 % (1 << CW));
    for (int i = 0; i < 5; i++) bbit(1'b1);
    check("R11 partial byte not counted", xfer_bytes, 2);
    bstart();
    check("R11 start clears count", xfer_bytes, 0);
    bstop();

    async_en = 1;
    bstart(); addr_frame(OWN, 0, ack, sm);
    check("R7 nak in async mode", ack, 0);
    check("R7 flag set", async_hit, 1);
    check("R7 not selected", selected, 0);
    check("R7 one irq pulse", irq_cnt, 1);
    bstop();
    async_en = 0;
    bstart(); addr_frame(OWN ^ 7'h40, 0, ack, sm); bstop();
    wq(4);
    check("R8 flag kept without clear", async_hit, 1);
    @(negedge clk) async_clr = 1;
    @(negedge clk) async_clr = 0;
    check("R8 flag cleared by write one", async_hit, 0);
    check("R7 no extra irq", irq_cnt, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule